// File: doc/BRIEF.md
# Serial Link Signal Detect Qualifier

This block qualifies a recovered 10-bit character stream. It drives a registered `sig_ok` flag that is high only while the stream looks like a live Fibre Channel or Gigabit Ethernet link. It takes one character per receive clock and a transition flag from an external amplitude comparator. It passes the characters to `char_out` without change.

Three things can fail a four-clock evaluation period:
- the transition flag being low on any clock of the period;
- a character of all zeros or all ones;
- the lack of a negative-disparity K28.5 comma in the most recent long comma window.

The verdict for one period is shown on `sig_ok` for the whole of the next period. Two mode inputs select which of these checks count. The wrap input puts the block in loopback mode, where only the transition check remains. The comma-ignore input removes only the comma check. The mode is captured at period boundaries.

Top module: `sigdet_qualifier`

## Requirements
- R1: While reset is high, and after reset until a full comma window has completed with a comma seen, `sig_ok` is low in normal mode. Reset is synchronous and active high.
- R2: `sig_ok` changes only at four-clock period boundaries. The period counter is free-running and starts at phase 0 on the first clock after reset. The verdict for a period appears on the clock edge that ends it and holds for the next four clocks.
- R3: `rx_trans` passes through a two-flop synchronizer. The synchronized flag being low on any clock of a period makes that period's verdict low.
- R4: A character equal to 0 (all ten bits clear) in a period makes that period's verdict low, when the zeros/ones check is enabled.
- R5: A character equal to 10'h3FF (all ten bits set) in a period makes that period's verdict low, when the zeros/ones check is enabled.
- R6: The comma is 0011111010 read R0 first, with `rx_char[0]` holding R0. As a vector this is 10'h17C, and it must match exactly. A free-running window of WINDOW characters (65,560 by default) starts at zero after reset. If a window ends without a comma, the comma check fails for every period of the next window. If the window contained a comma, the check passes for the next window.
- R7: With `wrap_en`=0 and `comma_ign_en`=1 the comma check is disabled. The transition check and the zeros/ones check stay active. A disabled check always passes.
- R8: With `wrap_en`=1 only the transition check is active, whatever the value of `comma_ign_en`.
- R9: The mode inputs are sampled on the last clock of each period, and the sampled mode governs the next period. The first period after reset uses normal mode, with every check enabled.
- R10: `char_out` equals `rx_char` on every cycle, whatever the detect result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive character clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_char | input | 10 | Received character, bit 0 is R0 |
| rx_trans | input | 1 | Asynchronous transition/amplitude flag |
| wrap_en | input | 1 | Loopback mode select |
| comma_ign_en | input | 1 | Comma check disable |
| char_out | output | 10 | Unaltered character pass-through |
| sig_ok | output | 1 | Registered signal-detect result |

## Verification
A clean stream, with ordinary characters, the flag held high and periodic commas, shows that the block can rise at all. It also pins down the latency of the comma window after reset. Single zeros, single ones and one-clock drops of the flag, each placed at varied phases, tell a per-period fault apart from a stuck or delayed one. A window with no comma separates the long comma verdict from the short per-period checks. Sweeps through the modes with the same faults, followed by random streams with random mode changes, show that each check is masked only in the modes that disable it and only from a period boundary on.

// File: rtl/sd_pkg.sv
package sd_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_NOCOMMA = 2'd1,
    MODE_LOOP    = 2'd2
  } sd_mode_e;

  typedef struct packed {
    logic zo_en;   // all-zeros / all-ones check active
    logic cm_en;   // comma presence check active
  } sd_checks_t;

  function automatic sd_mode_e mode_decode(input logic wrap, input logic ign);
    if (wrap)     return MODE_LOOP;
    else if (ign) return MODE_NOCOMMA;
    else          return MODE_NORMAL;
  endfunction

  function automatic sd_checks_t mode_checks(input sd_mode_e m);
    sd_checks_t c;
    c.zo_en = (m != MODE_LOOP);
    c.cm_en = (m == MODE_NORMAL);
    return c;
  endfunction

endpackage

// File: rtl/sd_sync.sv
module sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/sd_comma_mon.sv
module sd_comma_mon #(
  parameter int          CHAR_W = 10,
  parameter int          WINDOW = 65560,
  parameter logic [9:0]  COMMA  = 10'h17C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] ch,
  output logic              comma_ok
);
  localparam int CW = $clog2(WINDOW);

  logic [CW-1:0] wc;
  logic          seen;
  logic          hit;
  logic          win_end;

  assign hit     = (ch == CHAR_W'(COMMA));
  assign win_end = (wc == CW'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wc       <= '0;
      seen     <= 1'b0;
      comma_ok <= 1'b0;
    end else if (win_end) begin
      wc       <= '0;
      seen     <= 1'b0;
      comma_ok <= seen | hit;
    end else begin
      wc       <= wc + 1'b1;
      seen     <= seen | hit;
    end
  end

  // R6: the verdict only moves at a window boundary
  p_comma_window_r6: assert property (@(posedge clk) disable iff (rst)
    (wc != '0) |-> $stable(comma_ok));
endmodule

// File: rtl/sd_period_eval.sv
module sd_period_eval
  import sd_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] ch,
  input  logic              trans_s,
  input  logic              comma_ok,
  input  logic              wrap_en,
  input  logic              comma_ign_en,
  output logic              sig_ok
);
  localparam int PW = $clog2(PERIOD);

  logic [PW-1:0] ph;
  logic          acc_fail;
  sd_mode_e      mode_q;
  sd_checks_t    chk;
  logic          is_zero, is_ones, zo_hit, bad_now, comma_fail, last;

  assign chk        = mode_checks(mode_q);
  assign is_zero    = (ch == '0);
  assign is_ones    = &ch;
  assign zo_hit     = chk.zo_en && (is_zero || is_ones);
  assign bad_now    = !trans_s || zo_hit;
  assign comma_fail = chk.cm_en && !comma_ok;
  assign last       = (ph == PW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      acc_fail <= 1'b0;
      sig_ok   <= 1'b0;
      mode_q   <= MODE_NORMAL;
    end else if (last) begin
      ph       <= '0;
      acc_fail <= 1'b0;
      sig_ok   <= !(acc_fail || bad_now || comma_fail);
      mode_q   <= mode_decode(wrap_en, comma_ign_en);
    end else begin
      ph       <= ph + 1'b1;
      acc_fail <= acc_fail || bad_now;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ph != '0) |-> $stable(sig_ok));

  p_trans_low_r3: assert property (@(posedge clk) disable iff (rst)
    (last && !trans_s) |=> !sig_ok);

  p_zero_fail_r4: assert property (@(posedge clk) disable iff (rst)
    (last && chk.zo_en && is_zero) |=> !sig_ok);

  p_ones_fail_r5: assert property (@(posedge clk) disable iff (rst)
    (last && chk.zo_en && is_ones) |=> !sig_ok);

  p_comma_fail_r6: assert property (@(posedge clk) disable iff (rst)
    (last && chk.cm_en && !comma_ok) |=> !sig_ok);

  p_loop_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LOOP) |-> !chk.zo_en && !chk.cm_en);
endmodule

// File: rtl/sigdet_qualifier.sv
module sigdet_qualifier #(
  parameter int CHAR_W      = 10,
  parameter int PERIOD      = 4,
  parameter int WINDOW      = 65560,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_trans,
  input  logic              wrap_en,
  input  logic              comma_ign_en,
  output logic [CHAR_W-1:0] char_out,
  output logic              sig_ok
);
  logic trans_s;
  logic comma_ok;

  assign char_out = rx_char;

  sd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_trans),
    .q   (trans_s)
  );

  sd_comma_mon #(.CHAR_W(CHAR_W), .WINDOW(WINDOW)) u_comma (
    .clk      (clk),
    .rst      (rst),
    .ch       (rx_char),
    .comma_ok (comma_ok)
  );

  sd_period_eval #(.CHAR_W(CHAR_W), .PERIOD(PERIOD)) u_eval (
    .clk          (clk),
    .rst          (rst),
    .ch           (rx_char),
    .trans_s      (trans_s),
    .comma_ok     (comma_ok),
    .wrap_en      (wrap_en),
    .comma_ign_en (comma_ign_en),
    .sig_ok       (sig_ok)
  );
endmodule

// File: tb/test_sigdet_qualifier.sv
`timescale 1ns/1ps
module test_sigdet_qualifier;
  localparam int W     = 40;
  localparam int CHW   = 10;
  localparam logic [9:0] COMMA = 10'h17C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CHW-1:0] rx_char = '0;
  logic rx_trans = 1'b0, wrap_en = 1'b0, comma_ign_en = 1'b0;
  logic [CHW-1:0] char_out;
  logic sig_ok;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state
  logic m_h1, m_h2, m_acc, m_wrap, m_ign, m_seen, m_cok, m_sig;
  int   m_ph, m_wc;

  always #10 clk = ~clk;

  sigdet_qualifier #(.WINDOW(W)) i_sigdet_qualifier (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_trans(rx_trans),
    .wrap_en(wrap_en), .comma_ign_en(comma_ign_en),
    .char_out(char_out), .sig_ok(sig_ok)
  );

  function automatic logic char_bad(input logic [9:0] c, input logic wrap);
    return !wrap && (c == 10'h000 || c == 10'h3FF);
  endfunction

  function automatic logic [9:0] plain_char();
    logic [9:0] c;
    do c = 10'($urandom); while (c == 10'h000 || c == 10'h3FF || c == COMMA);
    return c;
  endfunction

  task automatic model_reset();
    m_h1 = 0; m_h2 = 0; m_acc = 0; m_wrap = 0; m_ign = 0;
    m_seen = 0; m_cok = 0; m_sig = 0; m_ph = 0; m_wc = 0;
  endtask

  task automatic model_clock();
    logic ts, bad, cm_en, hit;
    ts    = m_h2;
    m_h2  = m_h1;
    m_h1  = rx_trans;
    cm_en = !m_wrap && !m_ign;
    bad   = !ts || char_bad(rx_char, m_wrap);
    hit   = (rx_char == COMMA);
    if (m_ph == 3) begin
      m_sig  = !(m_acc || bad || (cm_en && !m_cok));
      m_acc  = 0;
      m_wrap = wrap_en;
      m_ign  = comma_ign_en;
      m_ph   = 0;
    end else begin
      m_acc = m_acc || bad;
      m_ph  = m_ph + 1;
    end
    if (m_wc == W - 1) begin
      m_cok  = m_seen || hit;
      m_seen = 0;
      m_wc   = 0;
    end else begin
      m_seen = m_seen || hit;
      m_wc   = m_wc + 1;
    end
  endtask

  task automatic check_sig();
    checks++;
    if (sig_ok !== m_sig) begin
      errors++;
      $display("FAIL %s: sig_ok=%0b expected %0b at t=%0t", tag, sig_ok, m_sig, $time);
    end
  endtask

  // drive at the negedge, clock once, check at the following negedge
  task automatic step(input logic [9:0] c, input logic tr);
    rx_char  = c;
    rx_trans = tr;
    #1;
    checks++;
    if (char_out !== c) begin
      errors++;
      $display("FAIL R10: char_out=%h expected %h", char_out, c);
    end
    @(posedge clk);
    model_clock();
    @(negedge clk);
    check_sig();
  endtask

  task automatic clean(input int n, input int comma_every);
    for (int i = 0; i < n; i++)
      step((comma_every > 0 && i % comma_every == 0) ? COMMA : plain_char(), 1'b1);
  endtask

  task automatic set_mode(input logic w, input logic g);
    wrap_en = w;
    comma_ign_en = g;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5d17));
    model_reset();
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_sig();
    rst = 1'b0;
    tag = "R1";
    clean(W, 20);                  // first window: still low
    tag = "R2";
    clean(2 * W, 20);              // rises once a good window is known
    tag = "R4";
    clean(5, 20); step(10'h000, 1'b1); clean(11, 20);
    clean(6, 20); step(10'h000, 1'b1); clean(9, 20);
    tag = "R5";
    clean(3, 20); step(10'h3FF, 1'b1); clean(12, 20);
    tag = "R3";
    clean(2, 20); step(plain_char(), 1'b0); clean(13, 20);
    clean(7, 20); step(plain_char(), 1'b0); clean(8, 20);
    tag = "R6";
    clean(W + 1, 0);               // window without commas
    clean(3 * W, 19);              // recovery
    tag = "R7";
    set_mode(1'b0, 1'b1);
    clean(2 * W, 0);               // no commas, still high
    step(10'h000, 1'b1); clean(7, 0);
    step(10'h3FF, 1'b1); clean(7, 0);
    step(plain_char(), 1'b0); clean(7, 0);
    tag = "R8";
    set_mode(1'b1, 1'b0);
    clean(W, 0);
    step(10'h000, 1'b1); clean(5, 0); step(10'h3FF, 1'b1); clean(5, 0);
    set_mode(1'b1, 1'b1);
    step(10'h000, 1'b1); clean(9, 0);
    step(plain_char(), 1'b0); clean(9, 0);
    tag = "R9";
    set_mode(1'b0, 1'b0);          // comma check resumes only at a boundary
    clean(2, 0); step(10'h000, 1'b1); clean(W, 0);
    set_mode(1'b1, 1'b0); clean(1, 0);
    set_mode(1'b0, 1'b0); clean(8, 0);
    tag = "R9_random";
    for (int i = 0; i < 3000; i++) begin
      logic [9:0] c;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2)      c = 10'h000;
      else if (r < 4) c = 10'h3FF;
      else if (r < 9) c = COMMA;
      else            c = plain_char();
      if (i % 7 == 0) set_mode(1'($urandom), ($urandom_range(0, 3) == 0));
      step(c, ($urandom_range(0, 40) != 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule